// File: doc/BRIEF.md
# Streaming ROM Block Verifier

The block checks the contents of an on-chip ROM against a stream of expected bytes that an outside tester supplies on a data port. The block drives no address out. After reset is released, an internal pointer starts at ROM address zero. Each rising edge of the address-latch strobe starts one compare. A fixed number of clock edges later, the byte on the data port is taken and compared with the ROM word at the pointer, and then the pointer steps to the next address. The tester has to keep its own count in step with this pointer.

Mismatches are gathered over blocks of sixteen compares. When the sixteenth compare of a block completes, one status pin takes the result of the whole block: high for pass, low for fail. The pin then holds that level while the next block is checked, so the result always trails the stream by one block. The ROM contents come from a behavioural model that computes each byte from its address and two parameters. At the top of the ROM, a parameter chooses whether the pointer wraps to zero or stays on the last address. The block needs a running clock throughout.

Top module: `rom_stream_verifier`

## Requirements
- R1: While reset is low, and after its release until the first block of 16 compares completes, `verdict` is high. Reset also returns the pointer to address 0 and discards any partial block.
- R2: A compare starts on the clock edge where `ale` is seen high after having been low on the previous edge. `data_in` is sampled on exactly the SAMPLE_CYC-th clock edge after that edge (default 3, i.e. six clock phases). Its value on every other edge has no effect.
- R3: The sampled byte is compared with the ROM byte at the pointer. The pointer is 0 for the first compare after reset and steps by one after each compare. The ROM byte at address A is ((A*37 + (A>>8)) mod 256) XOR 0x5A.
- R4: A rising edge of `ale` seen while a compare is still waiting for its sample point is ignored. It neither starts an extra compare nor moves the pointer.
- R5: `verdict` changes on the same edge as the 16th sample of a block. It goes low if any of the block's 16 compares mismatched, and high if all 16 matched.
- R6: Between block completions, `verdict` holds its level, whatever happens on `data_in`.
- R7: The mismatch record is cleared once each block completes, so a failing block does not make the next block fail.
- R8: With END_MODE = END_WRAP, the compare that follows address ROM_DEPTH-1 uses address 0. With END_MODE = END_HOLD, every compare after the one at address ROM_DEPTH-1 stays at address ROM_DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run during verification |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe; each rising edge starts one compare |
| data_in | input | DATA_W | Expected ROM byte supplied by the external tester |
| verdict | output | 1 | Result of the last completed block: 1 pass, 0 fail |

## Verification
The bench builds two copies of the block with ROM_DEPTH = 40, one set to END_WRAP and one to END_HOLD. The rest of the parameters keep their defaults (sample point 3 edges after the rise, 16 compares per block). Because 40 is not a multiple of 16, the pointer reaches the top of the ROM in the middle of the third block. A stream of a few hundred bytes therefore covers wrap-around, holding at the last address and block alignment across the ROM boundary. At the default depth of 32K bytes, the same coverage would take a stream of tens of thousands of bytes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Behaviour of the address pointer at the top of the ROM.
    typedef enum logic {
        END_WRAP = 1'b0,
        END_HOLD = 1'b1
    } rsv_end_e;

    // Behavioural ROM contents: a value computed from the address.
    function automatic logic [31:0] rsv_rom_word(input logic [31:0] addr,
                                                 input logic [31:0] mult,
                                                 input logic [31:0] seed);
        logic [31:0] mix;
        mix = (addr * mult) + (addr >> 8);
        return {24'd0, mix[7:0]} ^ seed;
    endfunction

endpackage

// File: rtl/rsv_strobe_gen.sv
// Finds each rising edge of the address-latch strobe and raises a one-cycle
// sample strobe SAMPLE_CYC clock edges after the edge that saw the rise.
module rsv_strobe_gen #(
    parameter int SAMPLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    output logic sample_stb
);
    localparam int CW = $clog2(SAMPLE_CYC + 1);

    typedef struct packed {
        logic          ale_seen;
        logic          pending;
        logic [CW-1:0] dly;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ale_seen = ale;
        sample_stb    = 1'b0;
        if (st_q.pending) begin
            // Any new rise while a sample is pending is ignored.
            if (st_q.dly == CW'(SAMPLE_CYC)) begin
                sample_stb   = 1'b1;
                st_d.pending = 1'b0;
                st_d.dly     = '0;
            end else begin
                st_d.dly = st_q.dly + 1'b1;
            end
        end else if (ale && !st_q.ale_seen) begin
            st_d.pending = 1'b1;
            st_d.dly     = CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rsv_rom_model.sv
// Behavioural ROM: each word is computed from its address.
module rsv_rom_model #(
    parameter int          ADDR_W = 15,
    parameter int          DATA_W = 8,
    parameter logic [31:0] MULT   = 32'd37,
    parameter logic [31:0] SEED   = 32'h5A
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    logic [31:0] full;

    always_comb begin
        full = rsv_pkg::rsv_rom_word(32'(addr), MULT, SEED);
        word = full[DATA_W-1:0];
    end

endmodule

// File: rtl/rsv_addr_ptr.sv
// Internal ROM address pointer; steps once per compare.
module rsv_addr_ptr #(
    parameter int               ROM_DEPTH = 32768,
    parameter int               ADDR_W    = 15,
    parameter rsv_pkg::rsv_end_e END_MODE  = rsv_pkg::END_WRAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ROM_DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ptr_t;

    ptr_t pt_d, pt_q;
    logic at_top;

    always_comb begin
        pt_d   = pt_q;
        at_top = (pt_q.addr == LAST);
        if (step) begin
            if (!at_top) begin
                pt_d.addr = pt_q.addr + 1'b1;
            end else if (END_MODE == rsv_pkg::END_WRAP) begin
                pt_d.addr = '0;
            end else begin
                pt_d.addr = LAST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign ptr = pt_q.addr;

endmodule

// File: rtl/rsv_group_acc.sv
// Accumulates mismatches over one block and publishes the block verdict.
module rsv_group_acc #(
    parameter int GROUP_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic mismatch,
    output logic grp_last,
    output logic verdict
);
    localparam int GW = $clog2(GROUP_LEN);

    typedef struct packed {
        logic          pass;
        logic          err;
        logic [GW-1:0] cnt;
    } acc_t;

    acc_t ac_d, ac_q;

    always_comb begin
        ac_d     = ac_q;
        grp_last = (ac_q.cnt == GW'(GROUP_LEN - 1));
        if (sample_stb) begin
            if (grp_last) begin
                ac_d.pass = !(ac_q.err || mismatch);
                ac_d.err  = 1'b0;
                ac_d.cnt  = '0;
            end else begin
                ac_d.err = ac_q.err || mismatch;
                ac_d.cnt = ac_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q <= '{pass: 1'b1, err: 1'b0, cnt: '0};
        end else begin
            ac_q <= ac_d;
        end
    end

    assign verdict = ac_q.pass;

endmodule

// File: rtl/rom_stream_verifier.sv
module rom_stream_verifier #(
    parameter int                ROM_DEPTH  = 32768,
    parameter int                DATA_W     = 8,
    parameter int                GROUP_LEN  = 16,
    parameter int                SAMPLE_CYC = 3,
    parameter rsv_pkg::rsv_end_e END_MODE   = rsv_pkg::END_WRAP,
    parameter logic [31:0]       ROM_MULT   = 32'd37,
    parameter logic [31:0]       ROM_SEED   = 32'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] data_in,
    output logic              verdict
);
    localparam int ADDR_W = $clog2(ROM_DEPTH);

    logic              sample_stb;
    logic              mismatch;
    logic              grp_last;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] rom_word;

    rsv_strobe_gen #(
        .SAMPLE_CYC(SAMPLE_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .sample_stb(sample_stb)
    );

    rsv_addr_ptr #(
        .ROM_DEPTH(ROM_DEPTH),
        .ADDR_W   (ADDR_W),
        .END_MODE (END_MODE)
    ) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (sample_stb),
        .ptr  (ptr)
    );

    rsv_rom_model #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .MULT  (ROM_MULT),
        .SEED  (ROM_SEED)
    ) u_rom (
        .addr(ptr),
        .word(rom_word)
    );

    assign mismatch = sample_stb && (data_in != rom_word);

    rsv_group_acc #(
        .GROUP_LEN(GROUP_LEN)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .mismatch  (mismatch),
        .grp_last  (grp_last),
        .verdict   (verdict)
    );

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int                ROM_DEPTH = 32768,
    parameter int                ADDR_W    = 15,
    parameter rsv_pkg::rsv_end_e END_MODE  = rsv_pkg::END_WRAP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_stb,
    input logic              grp_last,
    input logic              mismatch,
    input logic [ADDR_W-1:0] ptr,
    input logic              verdict
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ROM_DEPTH - 1);

    // R1: pass level in the first cycle after reset
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> verdict);

    // R2: samples are single-cycle and never back to back
    p_single_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R3: pointer steps by one after a compare below the top
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && ptr != LAST) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R4: pointer does not move without a compare
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(ptr));

    // R5: a mismatch in the closing compare fails the block
    p_fail_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && grp_last && mismatch) |=> !verdict);

    // R6: verdict moves only when a block closes
    p_static_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && grp_last) |=> $stable(verdict));

    // R8: behaviour at the top address
    p_top_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && ptr == LAST) |=>
            ptr == ((END_MODE == rsv_pkg::END_WRAP) ? '0 : LAST));

endmodule

bind rom_stream_verifier rsv_checker #(
    .ROM_DEPTH(ROM_DEPTH),
    .ADDR_W   (ADDR_W),
    .END_MODE (END_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_stb(sample_stb),
    .grp_last  (grp_last),
    .mismatch  (mismatch),
    .ptr       (ptr),
    .verdict   (verdict)
);

// File: tb/tb_rom_stream_verifier.sv
`timescale 1ns/1ps
module tb_rom_stream_verifier;

    localparam int DEPTH = 40;
    localparam int NGRP  = 6;
    // Per block: byte position to corrupt (16 = none), pulse style, expected verdict.
    localparam int   VEC_POS  [NGRP] = '{16, 0, 15, 16, 7, 16};
    localparam int   VEC_MODE [NGRP] = '{0, 0, 0, 2, 0, 1};
    localparam logic VEC_EXP  [NGRP] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0;
    logic [7:0] data_w = 8'h00;
    logic [7:0] data_s = 8'h00;
    logic       verdict_w, verdict_s;

    int checks = 0;
    int errors = 0;
    int ptr_w = 0;
    int ptr_s = 0;

    always #2.5 clk = ~clk;

    rom_stream_verifier #(.ROM_DEPTH(DEPTH), .END_MODE(rsv_pkg::END_WRAP)) dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .data_in(data_w), .verdict(verdict_w));

    rom_stream_verifier #(.ROM_DEPTH(DEPTH), .END_MODE(rsv_pkg::END_HOLD)) dut_sat (
        .clk(clk), .rst_n(rst_n), .ale(ale), .data_in(data_s), .verdict(verdict_s));

    function automatic logic [7:0] ref_byte(int a);
        int s;
        s = a * 37 + (a >>> 8);
        return 8'(s) ^ 8'h5A;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One compare; starts and ends on a falling edge.
    // mode 0 plain, 1 extra rise while pending, 2 data valid only at sample edge.
    task automatic send(logic corrupt, int mode);
        logic [7:0] gw, gs;
        gw = ref_byte(ptr_w) ^ {7'd0, corrupt};
        gs = ref_byte(ptr_s) ^ {7'd0, corrupt};
        ale    = 1'b1;
        data_w = (mode == 2) ? ~gw : gw;
        data_s = (mode == 2) ? ~gs : gs;
        @(negedge clk);
        if (mode == 1) ale = 1'b0;
        @(negedge clk);
        ale = (mode == 1);
        @(negedge clk);
        ale = 1'b0;
        data_w = gw;
        data_s = gs;
        @(negedge clk);
        if (mode == 2) begin
            data_w = ~gw;
            data_s = ~gs;
        end
        @(negedge clk);
        @(negedge clk);
        ptr_w = (ptr_w == DEPTH - 1) ? 0 : ptr_w + 1;
        ptr_s = (ptr_s == DEPTH - 1) ? DEPTH - 1 : ptr_s + 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ale   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "verdict in reset", verdict_w, 1'b1);
        rst_n = 1'b1;
        ptr_w = 0;
        ptr_s = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        @(negedge clk);
        do_reset();
        check("R1", "idle verdict wrap", verdict_w, 1'b1);
        check("R1", "idle verdict hold", verdict_s, 1'b1);

        prev = 1'b1;
        for (int g = 0; g < NGRP; g++) begin
            for (int b = 0; b < 16; b++) begin
                int m;
                m = (VEC_MODE[g] == 2) ? 2 : ((VEC_MODE[g] == 1 && b == 5) ? 1 : 0);
                send(VEC_POS[g] == b, m);
                if (b == 7) begin
                    check("R6", "mid-block wrap", verdict_w, prev);
                    check("R6", "mid-block hold", verdict_s, prev);
                end
            end
            // Blocks 2..5 cross the top of the ROM (R8); block 3 follows a fail (R7)
            // and uses a narrow data window (R2); block 5 has an extra rise (R4).
            check((g == 3) ? "R7 R2 R8" : (g == 5) ? "R4 R8" : "R5 R8",
                  "block verdict wrap", verdict_w, VEC_EXP[g]);
            check((g == 3) ? "R7 R2 R8" : (g == 5) ? "R4 R8" : "R5 R8",
                  "block verdict hold", verdict_s, VEC_EXP[g]);
            prev = VEC_EXP[g];
        end

        // Partial block with an error, then reset: record and pointer cleared.
        for (int b = 0; b < 5; b++) send(b == 2, 0);
        check("R6", "verdict during partial block", verdict_w, 1'b1);
        do_reset();
        check("R1", "verdict after reset", verdict_w, 1'b1);
        for (int b = 0; b < 16; b++) send(1'b0, 0);
        check("R3", "block from address 0 wrap", verdict_w, 1'b1);
        check("R3", "block from address 0 hold", verdict_s, 1'b1);
        for (int b = 0; b < 16; b++) send(b == 15, 0);
        check("R5", "last byte mismatch", verdict_w, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule